// File: doc/BRIEF.md
# Lazy-Stacking Fault Escalation Unit

This unit decides what becomes of a fault or debug-monitor exception that must be raised while floating-point context is being saved lazily. The decision does not use the live controller state. It uses the readiness flags that were captured together with the deferred FP context. There are two copies of those flags, one secure and one non-secure. The unit makes one of three choices:

- drop the request,
- pend the exception itself,
- escalate it to HardFault. Escalation also sets a sticky forced-fault status bit.

When the selected vector cannot preempt the running code and the saved context says HardFault is not ready, the unit raises a sticky lockup output instead of pending anything.

The result is registered. One clock after a request it appears as a one-cycle "set pending" pulse carrying the exception number and the bank of the vector to pend. The interrupt controller applies that pulse and uses it as its trigger to recompute priorities. Pending, enable and priority state for both banks stay in the controller and are fed in as vectors.

A separate combinational query port reports whether a given exception is ready: enabled, and able to interrupt the current execution priority. For HardFault it reports only whether the execution priority is above -1.

Top module: `lzx_escalate_unit`

## Requirements
- R1: A DebugMonitor request (number 12) is discarded with no pulse when bit 5 (monitor-ready) of the secure flag copy is clear; otherwise it pends 12 in bank 0.
- R2: MemManage (4) escalates when bit 1 of the selected flag copy is clear, and UsageFault (6) escalates when bit 3 of it is clear. The selected copy is the secure one when the bank selector is 1 and the non-secure one when it is 0. Without escalation the pulse carries the request's number and bank.
- R3: BusFault (5) escalates when bit 2 of the secure copy is clear, and SecureFault (7) escalates when bit 4 of the secure copy is clear; the non-secure copy is never consulted for them.
- R4: An escalated request pends HardFault (3) in bank 1 when the security extension is enabled and either the original fault targeted secure or the non-secure-HardFault-ownership input is 0; otherwise it pends HardFault in bank 0. A banked fault targets secure when its selector is 1; a non-banked fault uses its target-security input bit.
- R5: Every escalation sets the forced-fault output, which then stays 1 until reset.
- R6: The set pulse is high for exactly the cycle after the accepted request, and only if the chosen vector's pending input is 0.
- R7: Lockup is raised when bit 0 (HardFault-ready) of the secure copy is clear and the chosen vector is disabled or the execution priority is less than or equal to its group priority. In that cycle neither the pulse nor forced-fault is set. Lockup is sticky, and later requests are ignored.
- R8: The query for HardFault is 1 exactly when the execution priority is greater than -1, regardless of enable.
- R9: The query for any other exception is 1 exactly when that vector in the queried bank is enabled and its group priority is strictly less than the execution priority. Bank 1 applies only when the selector is 1.
- R10: Requests for any number other than 4, 5, 6, 7 or 12, or with the selector set for a non-banked exception, have no effect. Banked numbers are 3, 4, 6, 11, 14 and 15. A query with the selector set for a non-banked exception returns 0.
- R11: After reset the pulse, forced-fault and lockup outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Raise request during lazy FP save |
| req_exc | input | EXC_W | Requested exception number |
| req_sec | input | 1 | Bank selector for banked exceptions |
| ctx_flags_s | input | 6 | Secure readiness flags saved with FP context |
| ctx_flags_ns | input | 6 | Non-secure readiness flags saved with FP context |
| sec_ext_en | input | 1 | Security extension present |
| ns_owns_hf | input | 1 | HardFault/BusFault assigned to non-secure |
| tgt_sec | input | NUM_EXC | Per-exception target security for non-banked vectors |
| en_b0 | input | NUM_EXC | Enables, bank 0 |
| en_b1 | input | NUM_EXC | Enables, bank 1 (secure) |
| prio_b0 | input | 9*NUM_EXC | Signed priorities, bank 0, exception i at bits 9i+8:9i |
| prio_b1 | input | 9*NUM_EXC | Signed priorities, bank 1 |
| pend_b0 | input | NUM_EXC | Pending state, bank 0 |
| pend_b1 | input | NUM_EXC | Pending state, bank 1 |
| exec_prio | input | 9 | Signed current execution priority |
| qry_exc | input | EXC_W | Ready-query exception number |
| qry_sec | input | 1 | Ready-query bank selector |
| qry_ready | output | 1 | Ready-query result (combinational) |
| set_valid | output | 1 | One-cycle set-pending pulse / recompute trigger |
| set_exc | output | EXC_W | Exception number to pend |
| set_sec | output | 1 | Bank of the vector to pend |
| forced_hf | output | 1 | Sticky forced-escalation status |
| lockup | output | 1 | Sticky lockup indication |

## Verification
The hardest state to reach is the lockup path. It needs the HardFault-ready flag clear in the secure copy and, at the same time, a target vector that is disabled or sits exactly at the execution priority. The bench sets up that combination directly through the enable, priority and flag inputs. It then checks the equal-priority boundary against a priority one step above it, and sends a later request to show that lockup is sticky and that requests are ignored once it is set. Suppression by an already pending vector is reached by holding the secure HardFault pending input high while an escalating fault arrives.

// File: rtl/lzx_pkg.sv
package lzx_pkg;

    localparam int PW = 9;
    typedef logic signed [PW-1:0] prio_t;

    // exception numbers whose values the controller decodes
    localparam int unsigned X_HARD  = 3;
    localparam int unsigned X_MEM   = 4;
    localparam int unsigned X_BUS   = 5;
    localparam int unsigned X_USAGE = 6;
    localparam int unsigned X_SECF  = 7;
    localparam int unsigned X_MON   = 12;

    // readiness flag positions in each saved copy
    localparam int NFLAG   = 6;
    localparam int F_HF    = 0;
    localparam int F_MEM   = 1;
    localparam int F_BUS   = 2;
    localparam int F_USAGE = 3;
    localparam int F_SECF  = 4;
    localparam int F_MON   = 5;

    typedef enum logic [2:0] {
        K_NONE, K_MON, K_MEM, K_USAGE, K_BUS, K_SECF
    } kind_e;

    function automatic logic is_banked(input int unsigned n);
        return (n == 3) || (n == 4) || (n == 6) || (n == 11) || (n == 14) || (n == 15);
    endfunction

endpackage

// File: rtl/lzx_decode.sv
module lzx_decode
    import lzx_pkg::*;
#(
    parameter int NUM_EXC = 16,
    localparam int EXC_W = $clog2(NUM_EXC)
) (
    input  logic [EXC_W-1:0]   exc,
    input  logic               sec,
    input  logic [NFLAG-1:0]   flags_s,
    input  logic [NFLAG-1:0]   flags_ns,
    input  logic [NUM_EXC-1:0] tgt_sec,
    input  logic               sec_ext_en,
    input  logic               ns_owns_hf,
    output logic               legal,
    output logic               drop,
    output logic               escalate,
    output logic [EXC_W-1:0]   out_exc,
    output logic               out_sec
);
    kind_e               kind;
    logic [2:0]          flag_idx;
    logic                uses_bank;
    logic [NFLAG-1:0]    copy_sel;
    logic                flag_ok;
    logic                banked;
    logic                targets_sec;
    logic                in_range;

    always_comb begin
        kind      = K_NONE;
        flag_idx  = 3'(F_HF);
        uses_bank = 1'b0;
        case (int'(exc))
            X_MON:   begin kind = K_MON;   flag_idx = 3'(F_MON);   end
            X_MEM:   begin kind = K_MEM;   flag_idx = 3'(F_MEM);   uses_bank = 1'b1; end
            X_USAGE: begin kind = K_USAGE; flag_idx = 3'(F_USAGE); uses_bank = 1'b1; end
            X_BUS:   begin kind = K_BUS;   flag_idx = 3'(F_BUS);   end
            X_SECF:  begin kind = K_SECF;  flag_idx = 3'(F_SECF);  end
            default: kind = K_NONE;
        endcase
    end

    assign banked   = is_banked(int'(exc));
    assign in_range = (int'(exc) > 1) && (int'(exc) < NUM_EXC);
    assign legal    = in_range && (kind != K_NONE) && (!sec || banked);

    // banked faults read the copy named by the selector, the rest the secure copy
    assign copy_sel = (uses_bank && !sec) ? flags_ns : flags_s;
    assign flag_ok  = copy_sel[flag_idx];

    assign drop     = (kind == K_MON) && !flag_ok;
    assign escalate = (kind != K_MON) && (kind != K_NONE) && !flag_ok;

    assign targets_sec = banked ? sec : (in_range ? tgt_sec[exc] : 1'b0);

    always_comb begin
        if (escalate) begin
            out_exc = EXC_W'(X_HARD);
            out_sec = sec_ext_en && (targets_sec || !ns_owns_hf);
        end else begin
            out_exc = exc;
            out_sec = sec;
        end
    end

endmodule

// File: rtl/lzx_vec_pick.sv
module lzx_vec_pick
    import lzx_pkg::*;
#(
    parameter int NUM_EXC     = 16,
    parameter int SUBPRI_BITS = 0,
    localparam int EXC_W = $clog2(NUM_EXC),
    localparam int PV_W  = PW * NUM_EXC
) (
    input  logic [EXC_W-1:0]   exc,
    input  logic               bank,
    input  logic [NUM_EXC-1:0] en_b0,
    input  logic [NUM_EXC-1:0] en_b1,
    input  logic [PV_W-1:0]    prio_b0,
    input  logic [PV_W-1:0]    prio_b1,
    output logic               en,
    output prio_t              gprio
);
    localparam logic [PW-1:0] SUB_MASK = ~((PW'(1) << SUBPRI_BITS) - PW'(1));

    logic  in_range;
    prio_t raw;

    assign in_range = int'(exc) < NUM_EXC;

    always_comb begin
        en  = 1'b0;
        raw = '0;
        if (in_range) begin
            en  = bank ? en_b1[exc] : en_b0[exc];
            raw = bank ? prio_b1[int'(exc)*PW +: PW] : prio_b0[int'(exc)*PW +: PW];
        end
        // fixed negative levels are never split into group and sub-priority
        gprio = raw[PW-1] ? raw : (raw & SUB_MASK);
    end

endmodule

// File: rtl/lzx_ready.sv
module lzx_ready
    import lzx_pkg::*;
#(
    parameter int NUM_EXC = 16,
    localparam int EXC_W = $clog2(NUM_EXC)
) (
    input  logic [EXC_W-1:0] exc,
    input  logic             sec,
    input  logic             en,
    input  prio_t            gprio,
    input  prio_t            exec_prio,
    output logic             ready
);
    logic legal;

    assign legal = (int'(exc) > 1) && (int'(exc) < NUM_EXC) && (!sec || is_banked(int'(exc)));

    always_comb begin
        if (int'(exc) == X_HARD)
            ready = exec_prio > -9'sd1;
        else
            ready = legal && en && (gprio < exec_prio);
    end

endmodule

// File: rtl/lzx_escalate_unit.sv
module lzx_escalate_unit
    import lzx_pkg::*;
#(
    parameter int NUM_EXC     = 16,
    parameter int SUBPRI_BITS = 0,
    localparam int EXC_W = $clog2(NUM_EXC),
    localparam int PV_W  = 9 * NUM_EXC
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [EXC_W-1:0]   req_exc,
    input  logic               req_sec,
    input  logic [5:0]         ctx_flags_s,
    input  logic [5:0]         ctx_flags_ns,
    input  logic               sec_ext_en,
    input  logic               ns_owns_hf,
    input  logic [NUM_EXC-1:0] tgt_sec,
    input  logic [NUM_EXC-1:0] en_b0,
    input  logic [NUM_EXC-1:0] en_b1,
    input  logic [PV_W-1:0]    prio_b0,
    input  logic [PV_W-1:0]    prio_b1,
    input  logic [NUM_EXC-1:0] pend_b0,
    input  logic [NUM_EXC-1:0] pend_b1,
    input  logic signed [8:0]  exec_prio,
    input  logic [EXC_W-1:0]   qry_exc,
    input  logic               qry_sec,
    output logic               qry_ready,
    output logic               set_valid,
    output logic [EXC_W-1:0]   set_exc,
    output logic               set_sec,
    output logic               forced_hf,
    output logic               lockup
);
    typedef struct packed {
        logic             set_valid;
        logic [EXC_W-1:0] set_exc;
        logic             set_sec;
        logic             forced;
        logic             lockup;
    } state_t;

    state_t st_d, st_q;

    logic             dec_legal, dec_drop, dec_esc, dec_sec;
    logic [EXC_W-1:0] dec_exc;
    logic             pick_en, qpick_en;
    prio_t            pick_gprio, qpick_gprio;
    logic             qry_bank;

    lzx_decode #(.NUM_EXC(NUM_EXC)) u_decode (
        .exc        (req_exc),
        .sec        (req_sec),
        .flags_s    (ctx_flags_s),
        .flags_ns   (ctx_flags_ns),
        .tgt_sec    (tgt_sec),
        .sec_ext_en (sec_ext_en),
        .ns_owns_hf (ns_owns_hf),
        .legal      (dec_legal),
        .drop       (dec_drop),
        .escalate   (dec_esc),
        .out_exc    (dec_exc),
        .out_sec    (dec_sec)
    );

    lzx_vec_pick #(.NUM_EXC(NUM_EXC), .SUBPRI_BITS(SUBPRI_BITS)) u_pick_req (
        .exc     (dec_exc),
        .bank    (dec_sec),
        .en_b0   (en_b0),
        .en_b1   (en_b1),
        .prio_b0 (prio_b0),
        .prio_b1 (prio_b1),
        .en      (pick_en),
        .gprio   (pick_gprio)
    );

    assign qry_bank = qry_sec && is_banked(int'(qry_exc));

    lzx_vec_pick #(.NUM_EXC(NUM_EXC), .SUBPRI_BITS(SUBPRI_BITS)) u_pick_qry (
        .exc     (qry_exc),
        .bank    (qry_bank),
        .en_b0   (en_b0),
        .en_b1   (en_b1),
        .prio_b0 (prio_b0),
        .prio_b1 (prio_b1),
        .en      (qpick_en),
        .gprio   (qpick_gprio)
    );

    lzx_ready #(.NUM_EXC(NUM_EXC)) u_ready (
        .exc       (qry_exc),
        .sec       (qry_sec),
        .en        (qpick_en),
        .gprio     (qpick_gprio),
        .exec_prio (exec_prio),
        .ready     (qry_ready)
    );

    // next-state computation
    always_comb begin
        logic take;
        logic no_preempt;
        logic already;

        st_d           = st_q;
        st_d.set_valid = 1'b0;

        take       = req_valid && dec_legal && !dec_drop && !st_q.lockup;
        no_preempt = !pick_en || (exec_prio <= pick_gprio);
        already    = (int'(dec_exc) < NUM_EXC) ?
                     (dec_sec ? pend_b1[dec_exc] : pend_b0[dec_exc]) : 1'b0;

        if (take) begin
            if (no_preempt && !ctx_flags_s[F_HF]) begin
                st_d.lockup = 1'b1;
            end else begin
                if (dec_esc)
                    st_d.forced = 1'b1;
                if (!already) begin
                    st_d.set_valid = 1'b1;
                    st_d.set_exc   = dec_exc;
                    st_d.set_sec   = dec_sec;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign set_valid = st_q.set_valid;
    assign set_exc   = st_q.set_exc;
    assign set_sec   = st_q.set_sec;
    assign forced_hf = st_q.forced;
    assign lockup    = st_q.lockup;

endmodule

// File: rtl/lzx_escalate_chk.sv
module lzx_escalate_chk
    import lzx_pkg::*;
#(
    parameter int NUM_EXC = 16,
    localparam int EXC_W = $clog2(NUM_EXC)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             set_valid,
    input logic [EXC_W-1:0] set_exc,
    input logic             set_sec,
    input logic             forced_hf,
    input logic             lockup
);
    // R7
    lockup_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lockup |=> lockup);

    // R7
    no_pend_on_lockup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lockup) |-> !set_valid);

    // R7
    no_pend_after_lockup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lockup |=> !set_valid);

    // R5
    forced_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        forced_hf |=> forced_hf);

    // R5
    hard_pend_forced_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set_valid && int'(set_exc) == X_HARD) |-> forced_hf);

    // R6
    pulse_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_valid |-> $past(req_valid));

    // R10
    bank_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set_valid && set_sec) |-> is_banked(int'(set_exc)));

    // R10
    pend_number_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_valid |-> (int'(set_exc) inside {X_HARD, X_MEM, X_BUS, X_USAGE, X_SECF, X_MON}));

endmodule

bind lzx_escalate_unit lzx_escalate_chk #(.NUM_EXC(NUM_EXC)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .set_valid (set_valid),
    .set_exc   (set_exc),
    .set_sec   (set_sec),
    .forced_hf (forced_hf),
    .lockup    (lockup)
);

// File: tb/test_lzx_escalate_unit.sv
`timescale 1ns/1ps
module test_lzx_escalate_unit;
    localparam int N   = 16;
    localparam int EW  = 4;
    localparam int PVW = 9 * N;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [EW-1:0] req_exc = '0;
    logic req_sec = 1'b0;
    logic [5:0] fs = 6'h3F, fns = 6'h3F;
    logic sec_ext_en = 1'b1, ns_owns_hf = 1'b1;
    logic [N-1:0] tgt_sec = '0, en_b0 = '1, en_b1 = '1, pend_b0 = '0, pend_b1 = '0;
    logic [PVW-1:0] prio_b0, prio_b1;
    logic signed [8:0] exec_prio = 9'sd255;
    logic [EW-1:0] qry_exc = '0;
    logic qry_sec = 1'b0;
    logic qry_ready, set_valid, set_sec, forced_hf, lockup;
    logic [EW-1:0] set_exc;

    int checks = 0, fails = 0;
    bit done = 0;

    always #5 clk = ~clk;

    lzx_escalate_unit i_lzx_escalate_unit (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_exc(req_exc),
        .req_sec(req_sec), .ctx_flags_s(fs), .ctx_flags_ns(fns),
        .sec_ext_en(sec_ext_en), .ns_owns_hf(ns_owns_hf), .tgt_sec(tgt_sec),
        .en_b0(en_b0), .en_b1(en_b1), .prio_b0(prio_b0), .prio_b1(prio_b1),
        .pend_b0(pend_b0), .pend_b1(pend_b1), .exec_prio(exec_prio),
        .qry_exc(qry_exc), .qry_sec(qry_sec), .qry_ready(qry_ready),
        .set_valid(set_valid), .set_exc(set_exc), .set_sec(set_sec),
        .forced_hf(forced_hf), .lockup(lockup)
    );

    typedef struct packed {
        logic [3:0] exc; logic sec; logic [5:0] fs; logic [5:0] fns;
        logic sx; logic nso; logic tgt;
        logic ev; logic [3:0] eexc; logic esec; logic ef;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t TBL [NV] = '{
        '{4'd12, 1'b0, 6'h3F, 6'h3F, 1'b1, 1'b1, 1'b0, 1'b1, 4'd12, 1'b0, 1'b0}, // R1
        '{4'd12, 1'b0, 6'h1F, 6'h3F, 1'b1, 1'b1, 1'b0, 1'b0, 4'd0,  1'b0, 1'b0}, // R1
        '{4'd4,  1'b1, 6'h3F, 6'h00, 1'b1, 1'b1, 1'b0, 1'b1, 4'd4,  1'b1, 1'b0}, // R2
        '{4'd4,  1'b0, 6'h3F, 6'h3D, 1'b1, 1'b1, 1'b0, 1'b1, 4'd3,  1'b0, 1'b1}, // R2 R4
        '{4'd4,  1'b0, 6'h3F, 6'h3D, 1'b1, 1'b0, 1'b0, 1'b1, 4'd3,  1'b1, 1'b1}, // R4
        '{4'd6,  1'b1, 6'h37, 6'h3F, 1'b1, 1'b1, 1'b0, 1'b1, 4'd3,  1'b1, 1'b1}, // R4
        '{4'd6,  1'b0, 6'h37, 6'h3F, 1'b1, 1'b1, 1'b0, 1'b1, 4'd6,  1'b0, 1'b0}, // R2
        '{4'd5,  1'b0, 6'h3B, 6'h3F, 1'b1, 1'b1, 1'b0, 1'b1, 4'd3,  1'b0, 1'b1}, // R3
        '{4'd5,  1'b0, 6'h3F, 6'h00, 1'b1, 1'b1, 1'b0, 1'b1, 4'd5,  1'b0, 1'b0}, // R3
        '{4'd7,  1'b0, 6'h2F, 6'h3F, 1'b1, 1'b1, 1'b1, 1'b1, 4'd3,  1'b1, 1'b1}, // R3
        '{4'd7,  1'b0, 6'h2F, 6'h3F, 1'b0, 1'b1, 1'b1, 1'b1, 4'd3,  1'b0, 1'b1}, // R4
        '{4'd3,  1'b0, 6'h3F, 6'h3F, 1'b1, 1'b1, 1'b0, 1'b0, 4'd0,  1'b0, 1'b0}, // R10
        '{4'd5,  1'b1, 6'h3F, 6'h3F, 1'b1, 1'b1, 1'b0, 1'b0, 4'd0,  1'b0, 1'b0}, // R10
        '{4'd2,  1'b0, 6'h3F, 6'h3F, 1'b1, 1'b1, 1'b0, 1'b0, 4'd0,  1'b0, 1'b0}  // R10
    };

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic set_prio(input int idx, input int bank, input logic signed [8:0] p);
        if (bank == 0) prio_b0[idx*9 +: 9] = p;
        else           prio_b1[idx*9 +: 9] = p;
    endtask

    task automatic defaults;
        fs = 6'h3F; fns = 6'h3F; sec_ext_en = 1'b1; ns_owns_hf = 1'b1;
        tgt_sec = '0; en_b0 = '1; en_b1 = '1; pend_b0 = '0; pend_b1 = '0;
        exec_prio = 9'sd255;
        for (int i = 0; i < N; i++) begin
            set_prio(i, 0, 9'sd16);
            set_prio(i, 1, 9'sd16);
        end
        set_prio(3, 0, -9'sd1);
        set_prio(3, 1, -9'sd3);
    endtask

    task automatic do_reset;
        @(negedge clk);
        rst_n = 1'b0;
        req_valid = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // drive at a falling edge, let one rising edge register it, look at the next falling edge
    task automatic send(input int exc, input logic sec);
        @(negedge clk);
        req_exc = EW'(exc);
        req_sec = sec;
        req_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        defaults();
        repeat (2) @(negedge clk);
        // R11 reset state
        check("R11 set_valid", int'(set_valid), 0);
        check("R11 forced_hf", int'(forced_hf), 0);
        check("R11 lockup", int'(lockup), 0);
        rst_n = 1'b1;

        for (int v = 0; v < NV; v++) begin
            defaults();
            do_reset();
            fs = TBL[v].fs; fns = TBL[v].fns;
            sec_ext_en = TBL[v].sx; ns_owns_hf = TBL[v].nso;
            tgt_sec = {N{TBL[v].tgt}};
            send(int'(TBL[v].exc), TBL[v].sec);
            check($sformatf("R6 vec%0d pulse", v), int'(set_valid), int'(TBL[v].ev));
            if (TBL[v].ev) begin
                check($sformatf("R4 vec%0d exc", v), int'(set_exc), int'(TBL[v].eexc));
                check($sformatf("R4 vec%0d bank", v), int'(set_sec), int'(TBL[v].esec));
            end
            check($sformatf("R5 vec%0d forced", v), int'(forced_hf), int'(TBL[v].ef));
            check($sformatf("R7 vec%0d lockup", v), int'(lockup), 0);
            @(negedge clk);
            check($sformatf("R6 vec%0d one-cycle", v), int'(set_valid), 0);
        end

        // R6 already pending: escalation to secure HardFault with it pending
        defaults(); do_reset();
        pend_b1[3] = 1'b1; fs = 6'h37;
        send(6, 1'b1);
        check("R6 pending suppress", int'(set_valid), 0);
        check("R5 forced while pending", int'(forced_hf), 1);
        pend_b1[3] = 1'b0; fs = 6'h3F;
        send(4, 1'b1);
        check("R6 pulse after", int'(set_valid), 1);
        check("R5 forced sticky", int'(forced_hf), 1);

        // R7 lockup through a disabled vector, then sticky and ignoring requests
        defaults(); do_reset();
        en_b1[4] = 1'b0; fs = 6'h3E;
        send(4, 1'b1);
        check("R7 lockup raised", int'(lockup), 1);
        check("R7 no pulse", int'(set_valid), 0);
        check("R7 no forced", int'(forced_hf), 0);
        en_b1[4] = 1'b1; fs = 6'h3F;
        send(4, 1'b1);
        check("R7 ignored after lockup", int'(set_valid), 0);
        check("R7 lockup sticky", int'(lockup), 1);

        // R7 disabled vector with HardFault-ready set pends normally
        defaults(); do_reset();
        en_b1[4] = 1'b0;
        send(4, 1'b1);
        check("R7 disabled ok pulse", int'(set_valid), 1);
        check("R7 disabled ok nolock", int'(lockup), 0);

        // R7 priority boundary
        defaults(); do_reset();
        fs = 6'h1E; exec_prio = 9'sd16;
        fs = 6'h3E;
        send(12, 1'b0);
        check("R7 equal prio lockup", int'(lockup), 1);
        defaults(); do_reset();
        fs = 6'h3E; exec_prio = 9'sd17;
        send(12, 1'b0);
        check("R7 above prio nolock", int'(lockup), 0);
        check("R7 above prio pulse", int'(set_valid), 1);

        // R8 HardFault query ignores enable
        defaults();
        en_b0[3] = 1'b0; en_b1[3] = 1'b0;
        qry_exc = 4'd3; qry_sec = 1'b0; exec_prio = 9'sd0; #1;
        check("R8 hf exec0", int'(qry_ready), 1);
        exec_prio = -9'sd1; #1;
        check("R8 hf exec-1", int'(qry_ready), 0);

        // R9 other exceptions
        defaults();
        set_prio(4, 0, 9'sd20);
        qry_exc = 4'd4; qry_sec = 1'b1; exec_prio = 9'sd17; #1;
        check("R9 prio below", int'(qry_ready), 1);
        exec_prio = 9'sd16; #1;
        check("R9 prio equal", int'(qry_ready), 0);
        exec_prio = 9'sd18; #1;
        check("R9 bank1", int'(qry_ready), 1);
        qry_sec = 1'b0; #1;
        check("R9 bank0", int'(qry_ready), 0);
        qry_sec = 1'b1; en_b1[4] = 1'b0; #1;
        check("R9 disabled", int'(qry_ready), 0);
        qry_exc = 4'd5; qry_sec = 1'b1; #1;
        check("R10 query nonbanked sel", int'(qry_ready), 0);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule